// File: doc/BRIEF.md
# Hypercube E-Cube Wormhole Router Node

This block is one node of a binary hypercube network with `2^DIMS` nodes. Each node has one link per dimension plus a local port, which the attached endpoint uses to inject and receive packets. A packet is a worm of flits. The first flit carries the destination node address, and a marker bit closes the worm on its last flit. The router compares the destination with its own address, which is supplied on `self_addr`. It sends the worm out on the lowest dimension in which the two addresses still differ. When no bit differs, it delivers the worm to the local port.

Every input holds exactly one flit. A header flit claims an output port through a round-robin arbiter that belongs to that output. The output then stays bound to the winning input until the closing flit has crossed it. A header that loses waits in its input slot. All links use a request/ready pair, and a flit moves only on a cycle in which both are high. Flits are never discarded.

Top module: `hc_ecube_router`

## Requirements
- R1: During and right after reset, every `out_req` bit is low and every `in_rdy` bit is high.
- R2: A header flit whose destination differs from `self_addr` leaves on port d, where d is the lowest bit position set in (destination XOR `self_addr`). Ports 0 to DIMS-1 are the dimension links in bit order.
- R3: Flit layout is as follows. Bit FW-1 is the closing (tail) marker. Bit FW-2 is the header marker. The low DATA_W bits are the payload. In a header, the low DIMS payload bits hold the destination address. A one-flit packet sets both marker bits.
- R4: All flits of a packet leave on the port chosen by its header, in the order they entered.
- R5: A header whose destination equals `self_addr` leaves on the local port, which is index DIMS.
- R6: Once a header has claimed an output, no flit from another input appears on that output until the claiming packet's tail flit has passed. After that the output is free for the next header.
- R7: Each output port keeps its own arbiter. Out of reset, it favours the lowest-numbered input. After each grant, the search for the next grant starts at the input just after the one last granted.
- R8: While `out_req` is high and `out_rdy` is low, the output keeps `out_req` high and holds `out_flit` unchanged. No flit is lost or duplicated.
- R9: An input whose single flit slot is occupied drives `in_rdy` low until that flit has been forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| self_addr | input | DIMS | Address of this node |
| in_req | input | DIMS+1 | Flit offered on each input link |
| in_flit | input | (DIMS+1)*(DATA_W+2) | Flit on each input, port p at slice p |
| in_rdy | output | DIMS+1 | Input slot free to accept a flit |
| out_req | output | DIMS+1 | Flit offered on each output link |
| out_flit | output | (DIMS+1)*(DATA_W+2) | Flit on each output, port p at slice p |
| out_rdy | input | DIMS+1 | Downstream ready on each output |

## Verification
A stale or wrong output lock shows in one of two ways. Either a second worm's flits appear inside a running worm, or a port hangs forever with its input slot full. Both are visible within a few cycles of the next header. A wrong route computation puts a header on a port whose low address bits do not match the e-cube rule, one cycle after the header reaches the slot. A damaged arbiter pointer changes which of two simultaneous worms leaves first, and so is caught the first time two inputs contend.

// File: rtl/hc_pkg.sv
// Shared helpers for the hypercube router.
// Assumes at most 8 dimensions.
package hc_pkg;

    localparam int MAX_DIMS = 8;

    // Lowest differing dimension, or `dims` (local port) when addresses match
    function automatic logic [7:0] ecube_port(input logic [7:0] here,
                                              input logic [7:0] dest,
                                              input int         dims);
        logic [7:0] diff;
        logic [7:0] res;
        diff = here ^ dest;
        res  = 8'(dims);
        for (int i = MAX_DIMS - 1; i >= 0; i--) begin
            if (i < dims && diff[i]) res = 8'(i);
        end
        return res;
    endfunction

endpackage

// File: rtl/hc_inbuf.sv
// One-flit input slot.
// Accepts a flit when empty and releases it on pop.
// Assumes pop is only raised while the slot holds a flit.
module hc_inbuf #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [FW-1:0] push_flit,
    output logic          push_rdy,
    input  logic          pop,
    output logic          vld,
    output logic [FW-1:0] flit
);

    // Slot state: fill when empty, empty on pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            flit <= '0;
        end else if (pop) begin
            vld <= 1'b0;
        end else if (push_req && !vld) begin
            vld  <= 1'b1;
            flit <= push_flit;
        end
    end

    // Ready depends only on the slot register, so no path from downstream
    assign push_rdy = !vld;

endmodule

// File: rtl/hc_rr_pick.sv
// Combinational round-robin selector.
// Scans the inputs starting just after `last` and wraps around.
module hc_rr_pick #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] pick
);

    // First requester found after the last grant wins
    always_comb begin
        int idx;
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last) + k) % N;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/hc_outlock.sv
// Per-output allocator.
// Grants the output to one requesting header and keeps it bound to that input
// until the tail flit transfers.
// Assumes requests come only from headers that are not yet bound.
module hc_outlock #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          xfer_tail,
    output logic          lockd,
    output logic [IW-1:0] owner
);

    logic [IW-1:0] last;
    logic [IW-1:0] pick;
    logic          any;

    hc_rr_pick #(.N(N)) u_pick (
        .req  (req),
        .last (last),
        .any  (any),
        .pick (pick)
    );

    // Lock on a grant, release once the tail has passed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lockd <= 1'b0;
            owner <= '0;
            last  <= IW'(N - 1);
        end else if (lockd) begin
            if (xfer_tail) lockd <= 1'b0;
        end else if (any) begin
            lockd <= 1'b1;
            owner <= pick;
            last  <= pick;
        end
    end

endmodule

// File: rtl/hc_ecube_router.sv
// Hypercube router node with e-cube routing and wormhole switching.
// Ports 0..DIMS-1 are dimension links; port DIMS is local inject/eject.
// Flit = {tail, head, payload}; a header's low DIMS payload bits are the destination.
// Assumes self_addr is stable while packets are in flight.
module hc_ecube_router
    import hc_pkg::*;
#(
    parameter  int DIMS   = 3,
    parameter  int DATA_W = 8,
    localparam int NP     = DIMS + 1,
    localparam int FW     = DATA_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIMS-1:0]  self_addr,
    input  logic [NP-1:0]    in_req,
    input  logic [NP*FW-1:0] in_flit,
    output logic [NP-1:0]    in_rdy,
    output logic [NP-1:0]    out_req,
    output logic [NP*FW-1:0] out_flit,
    input  logic [NP-1:0]    out_rdy
);

    localparam int IW    = $clog2(NP);
    localparam int B_TL  = FW - 1;
    localparam int B_HD  = FW - 2;

    logic [NP-1:0] buf_vld;
    logic [NP-1:0] pop;
    logic [NP-1:0] owns;
    logic [FW-1:0] buf_flit [NP];
    logic [IW-1:0] dport    [NP];
    logic [NP-1:0] req_m    [NP];
    logic [NP-1:0] lockd;
    logic [IW-1:0] owner    [NP];

    // Input slots and route computation
    for (genvar i = 0; i < NP; i++) begin : g_in
        hc_inbuf #(.FW(FW)) u_ib (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_req  (in_req[i]),
            .push_flit (in_flit[i*FW +: FW]),
            .push_rdy  (in_rdy[i]),
            .pop       (pop[i]),
            .vld       (buf_vld[i]),
            .flit      (buf_flit[i])
        );
        assign dport[i] = IW'(ecube_port(8'(self_addr), 8'(buf_flit[i][DIMS-1:0]), DIMS));
    end

    // Which inputs are bound to an output, and which slots drain this cycle
    always_comb begin
        owns = '0;
        pop  = '0;
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                if (lockd[o] && owner[o] == IW'(i)) begin
                    owns[i] = 1'b1;
                    pop[i]  = buf_vld[i] && out_rdy[o];
                end
            end
        end
    end

    // Request matrix: unbound headers ask for their routed output
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_m[o][i] = buf_vld[i] && buf_flit[i][B_HD] && !owns[i]
                              && dport[i] == IW'(o);
            end
        end
    end

    // Output allocators and output muxes
    for (genvar o = 0; o < NP; o++) begin : g_out
        hc_outlock #(.N(NP)) u_ol (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_m[o]),
            .xfer_tail (out_req[o] && out_rdy[o] && out_flit[o*FW + B_TL]),
            .lockd     (lockd[o]),
            .owner     (owner[o])
        );
        assign out_req[o]          = lockd[o] && buf_vld[owner[o]];
        assign out_flit[o*FW +: FW] = buf_flit[owner[o]];
    end

endmodule

// File: rtl/hc_router_checker.sv
// Port-level properties of the router, attached by bind.
// Tracks whether each output is inside a worm.
module hc_router_checker #(
    parameter  int DIMS   = 3,
    parameter  int DATA_W = 8,
    localparam int NP     = DIMS + 1,
    localparam int FW     = DATA_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIMS-1:0]  self_addr,
    input logic [NP-1:0]    out_req,
    input logic [NP-1:0]    out_rdy,
    input logic [NP*FW-1:0] out_flit
);

    logic [NP-1:0] worm;

    // Inside-worm flag per output: set by a non-tail transfer, cleared by a tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            worm <= '0;
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (out_req[o] && out_rdy[o]) worm[o] <= !out_flit[o*FW + FW - 1];
            end
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_chk
        logic          hd;
        logic [DIMS-1:0] dst;
        assign hd  = out_flit[g*FW + FW - 2];
        assign dst = out_flit[g*FW +: DIMS];

        a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            out_req[g] && !out_rdy[g] |=> out_req[g] && $stable(out_flit[g*FW +: FW]));

        a_r6_no_head_in_worm: assert property (@(posedge clk) disable iff (!rst_n)
            out_req[g] && worm[g] |-> !hd);

        if (g < DIMS) begin : g_dim
            localparam int unsigned MASK = (1 << (g + 1)) - 1;
            localparam int unsigned BIT  = 1 << g;
            a_r2_lowest_dim: assert property (@(posedge clk) disable iff (!rst_n)
                out_req[g] && hd |-> ((dst ^ self_addr) & MASK[DIMS-1:0]) == BIT[DIMS-1:0]);
        end else begin : g_loc
            a_r5_local_eject: assert property (@(posedge clk) disable iff (!rst_n)
                out_req[g] && hd |-> dst == self_addr);
        end
    end

endmodule

bind hc_ecube_router hc_router_checker #(.DIMS(DIMS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .self_addr (self_addr),
    .out_req   (out_req),
    .out_rdy   (out_rdy),
    .out_flit  (out_flit)
);

// File: tb/test_hc_ecube_router.sv
`timescale 1ns/1ps
module test_hc_ecube_router;

    localparam int DIMS = 3;
    localparam int DW   = 8;
    localparam int NP   = DIMS + 1;
    localparam int FW   = DW + 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIMS-1:0]  self_addr;
    logic [NP-1:0]    in_req;
    logic [NP*FW-1:0] in_flit;
    logic [NP-1:0]    in_rdy;
    logic [NP-1:0]    out_req;
    logic [NP*FW-1:0] out_flit;
    logic [NP-1:0]    out_rdy;

    int errors = 0;
    int checks = 0;
    logic [FW-1:0] rec [NP][32];
    int            rcnt [NP];

    always #2.5 clk = ~clk;

    hc_ecube_router #(.DIMS(DIMS), .DATA_W(DW)) i_hc_ecube_router (
        .clk(clk), .rst_n(rst_n), .self_addr(self_addr),
        .in_req(in_req), .in_flit(in_flit), .in_rdy(in_rdy),
        .out_req(out_req), .out_flit(out_flit), .out_rdy(out_rdy)
    );

    // Vectors {self, input port, dest, expected output port}, one nibble each
    localparam logic [15:0] VEC [10] = '{
        16'h0350, 16'h0361, 16'h0342, 16'h5353, 16'h5012,
        16'h2170, 16'h7232, 16'h6063, 16'h3211, 16'h1300
    };

    // Record every output transfer (sampled mid-cycle)
    always @(negedge clk) begin
        for (int o = 0; o < NP; o++) begin
            if (rst_n && out_req[o] && out_rdy[o] && rcnt[o] < 32) begin
                rec[o][rcnt[o]] = out_flit[o*FW +: FW];
                rcnt[o]++;
            end
        end
    end

    function automatic logic [FW-1:0] mk(input bit t, input bit h, input logic [DW-1:0] p);
        return {t, h, p};
    endfunction

    // Expected flit k of a packet with given tag, destination and length
    function automatic logic [FW-1:0] pflit(input int tag, input int dest, input int len, input int k);
        if (k == 0) return mk(len == 1, 1'b1, DW'((tag << DIMS) | dest));
        return mk(k == len - 1, 1'b0, DW'(tag * 16 + k));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        for (int o = 0; o < NP; o++) rcnt[o] = 0;
    endtask

    task automatic send_flit(input int p, input logic [FW-1:0] f);
        @(posedge clk); #1;
        in_req[p] = 1'b1;
        in_flit[p*FW +: FW] = f;
        forever begin
            @(negedge clk);
            if (in_rdy[p]) break;
        end
        @(posedge clk); #1;
        in_req[p] = 1'b0;
    endtask

    task automatic send_pkt(input int p, input int dest, input int tag, input int len);
        for (int k = 0; k < len; k++) send_flit(p, pflit(tag, dest, len, k));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; in_req = '0; out_rdy = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        clear_rec();
    endtask

    // Check that packet (tag,dest,len) sits at position base on port o
    task automatic chk_pkt(input int o, input int base, input int tag, input int dest,
                           input int len, input string req);
        for (int k = 0; k < len; k++) begin
            chk(rec[o][base + k] == pflit(tag, dest, len, k), req,
                int'(rec[o][base + k]), int'(pflit(tag, dest, len, k)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_req = '0; in_flit = '0; out_rdy = '1; self_addr = '0;
        clear_rec();
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(out_req == '0, "R1 out_req idle", int'(out_req), 0);
        chk(in_rdy == '1, "R1 in_rdy free", int'(in_rdy), 15);

        // R2/R4/R5: routing table
        for (int v = 0; v < 10; v++) begin
            int s, ip, d, ep, tot;
            s = int'(VEC[v][15:12]); ip = int'(VEC[v][11:8]);
            d = int'(VEC[v][7:4]);   ep = int'(VEC[v][3:0]);
            @(posedge clk); #1;
            self_addr = DIMS'(s);
            clear_rec();
            send_pkt(ip, d, v, 3);
            idle(8);
            tot = 0;
            for (int o = 0; o < NP; o++) tot += rcnt[o];
            chk(rcnt[ep] == 3 && tot == 3, ep == DIMS ? "R5 local port" : "R2 dim port",
                rcnt[ep] * 16 + tot, 3 * 16 + 3);
            chk_pkt(ep, 0, v, d, 3, "R4 flit order");
        end

        // R8/R9: backpressure on port 1
        @(posedge clk); #1;
        self_addr = '0; clear_rec(); out_rdy[1] = 1'b0;
        fork
            send_pkt(3, 2, 11, 3);
        join_none
        repeat (10) @(negedge clk);
        chk(rcnt[1] == 0, "R8 nothing while stalled", rcnt[1], 0);
        chk(out_req[1] == 1'b1, "R8 request held", int'(out_req[1]), 1);
        chk(out_flit[FW +: FW] == pflit(11, 2, 3, 0), "R8 flit held",
            int'(out_flit[FW +: FW]), int'(pflit(11, 2, 3, 0)));
        chk(in_rdy[3] == 1'b0, "R9 slot full", int'(in_rdy[3]), 0);
        @(posedge clk); #1 out_rdy[1] = 1'b1;
        wait fork;
        idle(8);
        chk(rcnt[1] == 3, "R8 all delivered", rcnt[1], 3);
        chk_pkt(1, 0, 11, 2, 3, "R8 no loss");

        // R3/R6: one-flit packet releases the lock
        clear_rec();
        send_pkt(0, 2, 12, 1);
        send_pkt(3, 2, 13, 3);
        idle(8);
        chk(rcnt[1] == 4, "R6 release after tail", rcnt[1], 4);
        chk_pkt(1, 0, 12, 2, 1, "R3 single flit");
        chk_pkt(1, 1, 13, 2, 3, "R6 next worm");

        // R6/R7: contention after reset, input 0 favoured
        do_reset();
        fork
            send_pkt(0, 2, 14, 3);
            send_pkt(3, 2, 15, 3);
        join
        idle(8);
        chk(rcnt[1] == 6, "R6 both worms", rcnt[1], 6);
        chk_pkt(1, 0, 14, 2, 3, "R7 reset favours input 0");
        chk_pkt(1, 3, 15, 2, 3, "R6 no interleave");

        // R7: after granting input 1, input 3 is searched before input 0
        clear_rec();
        send_pkt(1, 2, 16, 3);
        idle(4);
        clear_rec();
        fork
            send_pkt(0, 2, 17, 3);
            send_pkt(3, 2, 18, 3);
        join
        idle(8);
        chk(rcnt[1] == 6, "R7 both worms", rcnt[1], 6);
        chk_pkt(1, 0, 18, 2, 3, "R7 rotation picks input 3");
        chk_pkt(1, 3, 17, 2, 3, "R7 input 0 second");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule